// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two independent interval timers behind a small synchronous register port. Each timer has two 16-bit stages, a prescale value and a divide value. When software writes either stage, the timer's down-counter reloads with (prescale + 1) × (divide + 1). The counter then counts down by one on every clock. When the count runs out, the timer raises a one-cycle pulse on its own output and reloads from the current stage values. Timer 0 drives the sample-rate pulse and timer 1 drives the tempo pulse. A separate interrupt controller latches and masks these pulses.

A stage value of zero stops its timer. The stages come out of reset at all-ones, but both counters come out of reset at zero, so neither timer runs until software writes one of its registers. A write may cover the whole 16-bit register or either byte of it. Every write restarts the timer that owns the register.

The register port is plain control: one write strobe, a byte/word qualifier, an address and write data. Read data is a combinational function of the address. There is no back-pressure, and every write takes effect at the clock edge that samples it.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, all four registers read 0xFFFF. Neither pulse output fires until a register is written.
- R2: Address bits [3:2] select the register: 0x0 is timer 0 prescale, 0x4 is timer 0 divide, 0x8 is timer 1 prescale, 0xC is timer 1 divide. With `wr_byte`=0, a write at one of these addresses stores all of `wdata`. A read returns the register selected by addr[3:2].
- R3: With `wr_byte`=1, only `wdata[7:0]` is used. At byte offset +0 it replaces bits 15:8, and at byte offset +1 it replaces bits 7:0. The other byte is kept.
- R4: With prescale p and divide d both nonzero, a timer's pulse first goes high in the cycle after the (p+1)(d+1)-th clock edge that follows the restarting write edge. It repeats every (p+1)(d+1) cycles after that.
- R5: If the prescale or the divide of a timer is zero, that timer produces no pulse.
- R6: Any accepted write to a timer's register, byte or word, restarts that timer's count from the write edge. The count of the other timer is not disturbed.
- R7: Each expiry pulse is exactly one cycle wide.
- R8: If a write to a timer lands on the edge at which that timer would expire, the write wins. No pulse is produced, and the next pulse comes a full period after the write.
- R9: A write with addr[1]=1, or a word write with addr[0]=1, is ignored. It changes no register and restarts no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_byte | input | 1 | 1 = byte write using wdata[7:0]; 0 = 16-bit write |
| addr | input | 4 | Byte address within the block |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Register selected by addr[3:2] |
| irq_sample | output | 1 | One-cycle expiry pulse of timer 0 |
| irq_tempo | output | 1 | One-cycle expiry pulse of timer 1 |

## Verification
Every pair of stage values in 0..3 is swept on each timer while the other timer is held stopped. Comparing both outputs on every cycle separates the correct product period from periods built as a sum or with an off-by-one, and the pairs with a zero stage confirm the stop rule. Byte writes to each half are read back against word writes to tell the two lanes apart and to show that the other byte is kept.

Timed writes are placed at three points:
- partway through a count, to show the restart;
- on the expiry edge itself, to show that the write wins;
- to the other timer or to an ignored lane, to show that the running count is not disturbed.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int NUM_TIMERS = 2;
  localparam int NUM_REGS   = 2 * NUM_TIMERS;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int ADDR_W     = IDX_W + 2;
  localparam int TMR_SAMPLE = 0;
  localparam int TMR_TEMPO  = 1;
endpackage

// File: rtl/dit_regfile.sv
module dit_regfile
  import dit_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              wr_byte,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [REG_W-1:0]                  wdata,
  output logic [REG_W-1:0]                  rdata,
  output logic [NUM_TIMERS-1:0][REG_W-1:0]  pre_q,
  output logic [NUM_TIMERS-1:0][REG_W-1:0]  div_q,
  output logic [NUM_TIMERS-1:0][REG_W-1:0]  pre_d,
  output logic [NUM_TIMERS-1:0][REG_W-1:0]  div_d,
  output logic [NUM_TIMERS-1:0]             restart
);
  localparam int HALF = REG_W / 2;

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q, regs_d;
  logic [IDX_W-1:0]               idx;
  logic                           lane_ok, wr_hit;

  assign idx     = addr[ADDR_W-1:2];
  assign lane_ok = !addr[1] && (wr_byte || !addr[0]);
  assign wr_hit  = wr_en && lane_ok;

  always_comb begin
    regs_d = regs_q;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (wr_hit && idx == IDX_W'(r)) begin
        if (!wr_byte)
          regs_d[r] = wdata;
        else if (!addr[0])
          regs_d[r][REG_W-1:HALF] = wdata[HALF-1:0];
        else
          regs_d[r][HALF-1:0] = wdata[HALF-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '1;
    else        regs_q <= regs_d;
  end

  assign rdata = regs_q[idx];

  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr_map
      assign pre_q[t]   = regs_q[2*t];
      assign div_q[t]   = regs_q[2*t+1];
      assign pre_d[t]   = regs_d[2*t];
      assign div_d[t]   = regs_d[2*t+1];
      assign restart[t] = wr_hit && (idx[IDX_W-1:1] == (IDX_W-1)'(t));
    end
  endgenerate

  AST_IGNORED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lane_ok) |=> $stable(regs_q)); // R9
  AST_HIGH_BYTE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_byte && !addr[0]) |=> (regs_q[$past(idx)][HALF-1:0] == $past(regs_q[idx][HALF-1:0]))); // R3
  AST_LOW_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_byte && addr[0]) |=> (regs_q[$past(idx)][REG_W-1:HALF] == $past(regs_q[idx][REG_W-1:HALF]))); // R3
endmodule

// File: rtl/dit_tick_counter.sv
module dit_tick_counter #(
  parameter int REG_W = 16,
  parameter int CNT_W = 2 * (REG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [REG_W-1:0] pre_q,
  input  logic [REG_W-1:0] div_q,
  input  logic [REG_W-1:0] pre_d,
  input  logic [REG_W-1:0] div_d,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] span_now, span_new;

  function automatic logic [CNT_W-1:0] span(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    logic [CNT_W-1:0] a1, b1;
    a1 = CNT_W'(a) + CNT_W'(1);
    b1 = CNT_W'(b) + CNT_W'(1);
    if (a == '0 || b == '0) return '0;
    return a1 * b1;
  endfunction

  assign span_now = span(pre_q, div_q);
  assign span_new = span(pre_d, div_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (restart) begin
        cnt_q <= span_new;
      end else if (cnt_q == CNT_W'(1)) begin
        cnt_q <= span_now;
        irq   <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !irq); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q == '0 || div_q == '0) |-> (cnt_q == '0 && !irq)); // R5
  AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_q) == CNT_W'(1))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CNT_W-1] == 1'b0); // R4
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq_sample,
  output logic              irq_tempo
);
  localparam int CNT_W = 2 * (REG_W + 1);

  logic [NUM_TIMERS-1:0][REG_W-1:0] pre_q, div_q, pre_d, div_d;
  logic [NUM_TIMERS-1:0]            restart;
  logic [NUM_TIMERS-1:0]            irq_vec;

  dit_regfile #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pre_q   (pre_q),
    .div_q   (div_q),
    .pre_d   (pre_d),
    .div_d   (div_d),
    .restart (restart)
  );

  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      dit_tick_counter #(.REG_W(REG_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart[t]),
        .pre_q   (pre_q[t]),
        .div_q   (div_q[t]),
        .pre_d   (pre_d[t]),
        .div_d   (div_d[t]),
        .irq     (irq_vec[t])
      );
    end
  endgenerate

  assign irq_sample = irq_vec[TMR_SAMPLE];
  assign irq_tempo  = irq_vec[TMR_TEMPO];

  AST_ONE_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(restart)); // R6
endmodule

// File: tb/dual_interval_timer_bench.sv
`timescale 1ns/1ps
module dual_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_byte = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_sample, irq_tempo;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_sample(irq_sample), .irq_tempo(irq_tempo)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // returns 1 ns after the edge that sampled the write
  task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input bit is_byte);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = is_byte; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_byte = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  function automatic logic irq_of(input int t);
    return (t == 0) ? irq_sample : irq_tempo;
  endfunction

  // compares both outputs each cycle; k counts edges after the reference write edge
  task automatic watch(input int p0, input int off0, input int p1, input int off1,
                       input int cycles, input string req);
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk); #1;
      check(irq_sample == ((p0 != 0) && (((k + off0) % p0) == 0)), req, irq_sample,
            (p0 != 0) && (((k + off0) % p0) == 0));
      check(irq_tempo == ((p1 != 0) && (((k + off1) % p1) == 0)), req, irq_tempo,
            (p1 != 0) && (((k + off1) % p1) == 0));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values and no pulses
    for (int r = 0; r < 4; r++) bus_read(4'(r * 4), 16'hFFFF, "R1 reset value");
    watch(0, 0, 0, 0, 60, "R1 quiet after reset");

    // R2: word map and readback
    bus_write(4'h0, 16'h1111, 0);
    bus_write(4'h4, 16'h2222, 0);
    bus_write(4'h8, 16'h3333, 0);
    bus_write(4'hC, 16'h4444, 0);
    bus_read(4'h0, 16'h1111, "R2 t0 prescale");
    bus_read(4'h4, 16'h2222, "R2 t0 divide");
    bus_read(4'h8, 16'h3333, "R2 t1 prescale");
    bus_read(4'hC, 16'h4444, "R2 t1 divide");

    // R3: byte lanes
    bus_write(4'h8, 16'h12AB, 1);
    bus_read(4'h8, 16'hAB33, "R3 high byte lane");
    bus_write(4'h9, 16'h34CD, 1);
    bus_read(4'h8, 16'hABCD, "R3 low byte lane");
    bus_write(4'h5, 16'h0077, 1);
    bus_read(4'h4, 16'h2277, "R3 low byte keeps high");

    // stop both timers
    bus_write(4'h0, 16'h0000, 0);
    bus_write(4'h8, 16'h0000, 0);
    watch(0, 0, 0, 0, 10, "R5 stopped");

    // R4/R5/R7 sweep on timer 0, timer 1 stopped
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        int per;
        per = (p == 0 || d == 0) ? 0 : (p + 1) * (d + 1);
        bus_write(4'h0, 16'(p), 0);
        bus_write(4'h4, 16'(d), 0);
        watch(per, 0, 0, 0, (per == 0) ? 20 : 2 * per + 2, "R4 R5 R7 timer0 sweep");
      end
    end
    bus_write(4'h0, 16'h0000, 0);

    // sweep on timer 1, timer 0 stopped
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        int per;
        per = (p == 0 || d == 0) ? 0 : (p + 1) * (d + 1);
        bus_write(4'h8, 16'(p), 0);
        bus_write(4'hC, 16'(d), 0);
        watch(0, 0, per, 0, (per == 0) ? 20 : 2 * per + 2, "R4 R5 R7 timer1 sweep");
      end
    end
    bus_write(4'h8, 16'h0000, 0);

    // R6: byte write mid-count restarts timer 0 (period 8)
    bus_write(4'h0, 16'h0001, 0);
    bus_write(4'h4, 16'h0003, 0);
    watch(8, 0, 0, 0, 3, "R6 before restart");
    bus_write(4'h5, 16'h0003, 1);
    watch(8, 0, 0, 0, 18, "R6 byte write restarts");

    // R6: write to timer 1 does not disturb timer 0
    bus_write(4'h4, 16'h0003, 0);
    watch(8, 0, 0, 0, 2, "R6 before other write");
    bus_write(4'h8, 16'h0000, 0);
    watch(8, 3, 0, 0, 14, "R6 other timer write");

    // R9: ignored lanes leave timer 0 running and registers intact
    bus_write(4'h4, 16'h0003, 0);
    watch(8, 0, 0, 0, 2, "R9 before ignored write");
    bus_write(4'h2, 16'h0000, 0);
    watch(8, 3, 0, 0, 3, "R9 word at +2 ignored");
    bus_write(4'h3, 16'h0000, 1);
    bus_write(4'h1, 16'h0000, 0);
    watch(8, 8, 0, 0, 9, "R9 byte +3 and word +1 ignored");
    bus_read(4'h0, 16'h0001, "R9 register intact");

    // R8: write on the expiry edge (period 4)
    bus_write(4'h4, 16'h0001, 0);
    watch(4, 0, 0, 0, 3, "R8 before expiry");
    bus_write(4'h0, 16'h0001, 0);
    check(irq_sample == 1'b0, "R8 write wins over expiry", irq_sample, 0);
    watch(4, 0, 0, 0, 9, "R8 full period after write");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule